// File: doc/BRIEF.md
# Multi-Channel Converter Result Mailbox

This block gathers conversion results from up to thirty converter input lines and keeps the latest result of each line in its own 32-bit slot. Each slot also carries two status flags. The first is a sticky flag that records that a result has ever arrived. The second is a fresh flag that marks data no reader has consumed yet. Sequencer tasks read any slot through a single read port. A read consumes the slot's freshness.

Each read returns its data one cycle after the request, split into an 8-bit upper byte and a 24-bit lower word. Together the two flags give four states: new data, data already consumed, nothing converted yet, and input line not wired. An input line is marked as unwired by a per-channel strap. Such a line always reports that last state.

Top module: `resultMailbox`

## Requirements
- R1: A read request (`rdEn` high, 5-bit `rdAddr`) puts the addressed slot on `rdHigh`/`rdLow` on the clock edge after the request. In any cycle that follows a cycle without a request, both outputs are zero.
- R2: Slot layout: bits 29:0 hold the payload, bit 30 is the fresh flag and bit 31 is the first-result flag. `rdHigh` carries slot bits 31:24, so bit 7 is the first-result flag, bit 6 is the fresh flag, and bits 5:0 are payload bits 29:24. `rdLow` carries payload bits 23:0.
- R3: A strobe on a connected channel stores that channel's 30-bit payload and sets its fresh flag and its first-result flag.
- R4: Once set, the first-result flag stays set through any number of reads and later strobes. Only reset clears it.
- R5: A read of a connected channel with no strobe on it in the same cycle clears that channel's fresh flag and leaves every other channel unchanged.
- R6: A channel whose strap marks it unconnected always reads as first-result 0, fresh 1 and payload zero. Strobes on it are ignored.
- R7: After reset, every connected channel reads as all zeros, meaning flags (0,0) and payload 0.
- R8: When a strobe and a read hit the same channel in one cycle, the read returns the value from before the update, and the fresh flag ends up set with the new payload stored.
- R9: A read with address 30 or 31 returns all zeros and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resStrobe | input | 30 | Per-channel new-result strobe |
| resPayload | input | 900 | Per-channel 30-bit payloads; channel i occupies bits i*30 +: 30 |
| lineConnected | input | 30 | Per-channel strap; 1 means the input line is wired |
| rdEn | input | 1 | Read request |
| rdAddr | input | 5 | Channel address of the read |
| rdHigh | output | 8 | Slot bits 31:24 of the previous cycle's read |
| rdLow | output | 24 | Slot bits 23:0 of the previous cycle's read |

## Verification
Capturing a new result and consuming freshness through a read can fall on the same channel in the same cycle. The update must win, and the read must still return the old slot. The bench provokes this both with a directed strobe-plus-read on one channel followed by a second read, and with thousands of random cycles in which strobes and reads overlap. A behavioural model decides every cycle which side wins and what the reader sees. Reads of unwired lines and of the two unused addresses are interleaved with these collisions, to show that neither disturbs stored state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int NUM_CH = 30;
  parameter int PAY_W = 30;
  parameter int HI_W = 8;
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int WORD_W = PAY_W + 2;
  localparam int LO_W = WORD_W - HI_W;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] capture;
    logic [NUM_CH-1:0] clrFresh;
    logic              rdHit;
    logic [ADDR_W-1:0] rdSel;
  } mbx_ctrl_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic [NUM_CH-1:0] resStrobe,
  input  logic [NUM_CH-1:0] lineConnected,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output mbx_ctrl_t         ctrl
);
  logic addrInRange;

  assign addrInRange = int'(rdAddr) < NUM_CH;

  always_comb begin
    ctrl = '0;
    ctrl.rdHit = rdEn && addrInRange;
    ctrl.rdSel = rdAddr;
    for (int i = 0; i < NUM_CH; i++) begin
      // unwired lines never take a result
      ctrl.capture[i] = resStrobe[i] && lineConnected[i];
      // a capture in the same cycle keeps freshness set
      ctrl.clrFresh[i] = ctrl.rdHit && (int'(rdAddr) == i) &&
                         lineConnected[i] && !resStrobe[i];
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  mbx_ctrl_t               ctrl,
  input  logic [NUM_CH*PAY_W-1:0] resPayload,
  input  logic [NUM_CH-1:0]       lineConnected,
  output logic [HI_W-1:0]         rdHigh,
  output logic [LO_W-1:0]         rdLow
);
  logic [PAY_W-1:0]  payQ [NUM_CH];
  logic [NUM_CH-1:0] firstQ;
  logic [NUM_CH-1:0] freshQ;
  logic [WORD_W-1:0] slotView [NUM_CH];
  logic [WORD_W-1:0] rdWordQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) payQ[i] <= '0;
      firstQ <= '0;
      freshQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctrl.capture[i]) begin
          payQ[i]   <= resPayload[i*PAY_W +: PAY_W];
          firstQ[i] <= 1'b1;
          freshQ[i] <= 1'b1;
        end else if (ctrl.clrFresh[i]) begin
          freshQ[i] <= 1'b0;
        end
      end
    end
  end

  // visible slot: unwired lines show the fixed (0,1) pattern
  for (genvar g = 0; g < NUM_CH; g++) begin : g_view
    assign slotView[g] = lineConnected[g] ? {firstQ[g], freshQ[g], payQ[g]}
                                          : {1'b0, 1'b1, {PAY_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdWordQ <= '0;
    else        rdWordQ <= ctrl.rdHit ? slotView[ctrl.rdSel] : '0;
  end

  assign rdHigh = rdWordQ[WORD_W-1 -: HI_W];
  assign rdLow  = rdWordQ[LO_W-1:0];
endmodule

// File: rtl/resultMailbox.sv
module resultMailbox
  import mbx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       resStrobe,
  input  logic [NUM_CH*PAY_W-1:0] resPayload,
  input  logic [NUM_CH-1:0]       lineConnected,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [HI_W-1:0]         rdHigh,
  output logic [LO_W-1:0]         rdLow
);
  mbx_ctrl_t ctrl;

  mbx_ctrl u_ctrl (
    .resStrobe     (resStrobe),
    .lineConnected (lineConnected),
    .rdEn          (rdEn),
    .rdAddr        (rdAddr),
    .ctrl          (ctrl)
  );

  mbx_datapath u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .resPayload    (resPayload),
    .lineConnected (lineConnected),
    .rdHigh        (rdHigh),
    .rdLow         (rdLow)
  );
endmodule

// File: rtl/resultMailbox_chk.sv
module resultMailbox_chk
  import mbx_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       resStrobe,
  input logic [NUM_CH*PAY_W-1:0] resPayload,
  input logic [NUM_CH-1:0]       lineConnected,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       rdAddr,
  input logic [HI_W-1:0]         rdHigh,
  input logic [LO_W-1:0]         rdLow
);
  logic inRange;
  assign inRange = int'(rdAddr) < NUM_CH;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> (rdHigh == '0 && rdLow == '0)); // R1

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !inRange) |=> (rdHigh == '0 && rdLow == '0)); // R9

  AST_UNWIRED_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && inRange && !lineConnected[rdAddr])
      |=> (rdHigh == 8'h40 && rdLow == '0)); // R6

  AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && inRange && lineConnected[rdAddr] && !resStrobe[rdAddr]) ##1
    (rdEn && rdAddr == $past(rdAddr) && lineConnected[rdAddr] && !resStrobe[rdAddr])
      |=> !rdHigh[HI_W-2]); // R5

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdHigh[HI_W-1] && $past(rdEn) && rdEn && rdAddr == $past(rdAddr) &&
     lineConnected[rdAddr])
      |=> rdHigh[HI_W-1]); // R4

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && inRange && lineConnected[rdAddr] && resStrobe[rdAddr]) ##1
    (rdEn && rdAddr == $past(rdAddr) && lineConnected[rdAddr])
      |=> (rdHigh[HI_W-1 -: 2] == 2'b11)); // R8
endmodule

bind resultMailbox resultMailbox_chk u_chk (.*);

// File: tb/resultMailbox_tb.sv
module resultMailbox_tb;
  import mbx_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                    rst_n;
  logic [NUM_CH-1:0]       resStrobe;
  logic [PAY_W-1:0]        payIn [NUM_CH];
  logic [NUM_CH*PAY_W-1:0] resPayload;
  logic [NUM_CH-1:0]       lineConnected;
  logic                    rdEn;
  logic [ADDR_W-1:0]       rdAddr;
  logic [HI_W-1:0]         rdHigh;
  logic [LO_W-1:0]         rdLow;

  always_comb
    for (int i = 0; i < NUM_CH; i++) resPayload[i*PAY_W +: PAY_W] = payIn[i];

  resultMailbox u_dut (.*);

  // behavioural reference
  logic [PAY_W-1:0]  mPay   [NUM_CH];
  bit                mFirst [NUM_CH];
  bit                mFresh [NUM_CH];
  logic [WORD_W-1:0] expWord;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [WORD_W-1:0] refView(int ch);
    if (!lineConnected[ch]) return {2'b01, {PAY_W{1'b0}}};
    return {mFirst[ch], mFresh[ch], mPay[ch]};
  endfunction

  task automatic cycle(string tag);
    expWord = (rdEn && int'(rdAddr) < NUM_CH) ? refView(int'(rdAddr)) : '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (lineConnected[ch]) begin
        if (resStrobe[ch]) begin
          mPay[ch] = payIn[ch]; mFirst[ch] = 1; mFresh[ch] = 1;
        end else if (rdEn && int'(rdAddr) == ch) begin
          mFresh[ch] = 0;
        end
      end
    end
    if (!rst_n) begin
      expWord = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        mPay[ch] = '0; mFirst[ch] = 0; mFresh[ch] = 0;
      end
    end
    @(negedge clk);
    total++;
    if ({rdHigh, rdLow} !== expWord) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, {rdHigh, rdLow}, expWord);
    end
    resStrobe = '0;
    rdEn = 1'b0;
  endtask

  task automatic strobe(int ch, logic [PAY_W-1:0] val);
    resStrobe[ch] = 1'b1;
    payIn[ch] = val;
  endtask

  task automatic readCh(int ch);
    rdEn = 1'b1;
    rdAddr = ADDR_W'(ch);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1: watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    lineConnected = {NUM_CH{1'b1}};
    lineConnected[7] = 1'b0;
    lineConnected[29] = 1'b0;
    resStrobe = '0; rdEn = 1'b0; rdAddr = '0;
    for (int i = 0; i < NUM_CH; i++) payIn[i] = '0;
    rst_n = 1'b0;
    @(negedge clk);
    repeat (3) cycle("R7");
    rst_n = 1'b1;
    cycle("R7");
    // reset state of every slot, and the unwired pattern
    for (int ch = 0; ch < NUM_CH; ch++) begin
      readCh(ch);
      cycle(lineConnected[ch] ? "R7" : "R6");
    end
    readCh(30); cycle("R9");
    readCh(31); cycle("R9");
    cycle("R1");
    // capture and field layout
    strobe(3, 30'h1234_5678); strobe(4, 30'h0ABC_DEF1); cycle("R3");
    readCh(3); cycle("R3");
    readCh(4); cycle("R2");
    strobe(12, 30'h2A5A_5A5A); cycle("R2");
    readCh(12); cycle("R2");
    // consumption
    readCh(3); cycle("R5");
    readCh(4); cycle("R5");
    readCh(12); cycle("R5");
    // sticky first-result flag
    strobe(3, 30'h0000_0001); cycle("R4");
    readCh(3); cycle("R4");
    readCh(3); cycle("R4");
    readCh(3); cycle("R4");
    // collision: strobe and read on one channel
    strobe(10, 30'h1111_1111); cycle("R8");
    readCh(10); strobe(10, 30'h2222_2222); cycle("R8");
    readCh(10); cycle("R8");
    readCh(10); cycle("R8");
    readCh(20); strobe(20, 30'h3333_3333); cycle("R8");
    readCh(20); cycle("R8");
    // unwired line ignores strobes
    strobe(7, 30'h3FFF_FFFF); cycle("R6");
    readCh(7); strobe(29, 30'h1555_5555); cycle("R6");
    readCh(29); cycle("R6");
    // unused addresses leave state alone
    strobe(5, 30'h0F0F_0F0F); cycle("R9");
    readCh(30); cycle("R9");
    readCh(31); cycle("R9");
    readCh(5); cycle("R9");
    // random overlap of strobes and reads
    for (int n = 0; n < 4000; n++) begin
      resStrobe = NUM_CH'($urandom & $urandom & $urandom);
      for (int i = 0; i < NUM_CH; i++) payIn[i] = PAY_W'($urandom);
      rdEn = ($urandom % 4) != 0;
      rdAddr = ADDR_W'($urandom);
      cycle("R1");
    end
    // reset is the only way to clear the first-result flag
    rst_n = 1'b0; cycle("R4");
    rst_n = 1'b1;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      readCh(ch);
      cycle("R4");
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule